// File: doc/BRIEF.md
# Three-Symbol Pattern Detector (Mealy)

This block watches a stream of 2-bit encoded symbols, one per rising clock edge, and flags the moment the ordered run a, b, c is completed. The flag is a Mealy output: it is computed combinationally from the current state and the symbol on the input right now. It therefore rises during the cycle in which the closing c is presented, not one cycle later.

Internally a three-state machine records how much of the pattern has been seen. The states are idle, "a seen" and "a then b seen". Every state change happens on the rising clock edge. An `a` always (re)starts the pattern, including when it arrives while the machine is waiting for the closing `c`. A synchronous, active-high reset returns the machine to idle and holds the flag low.

Top module: `seqdet_top`

## Requirements
- R1: While `rst` is high the flag `hit` is 0, and the first edge with `rst` high returns the machine to idle, so that a lone `c` after reset gives `hit` = 0.
- R2: Symbols are encoded on `symIn` as 2'b00 = a, 2'b01 = b, 2'b10 = c, 2'b11 = other.
- R3: In idle, symbol a moves to the "a seen" state and any other symbol stays idle. `hit` is 0 in both cases.
- R4: In "a seen", b moves to "a then b seen", a stays in "a seen" and c or other returns to idle. `hit` is 0 in all cases.
- R5: In "a then b seen", symbol c drives `hit` to 1 in that same cycle, and the next edge returns to idle.
- R6: In "a then b seen", symbol a gives `hit` = 0 and moves to "a seen", so that a following b, c completes a match (a,b,a,b,c raises `hit` on the last c).
- R7: In "a then b seen", symbol b or other gives `hit` = 0 and returns to idle.
- R8: `hit` follows a change of `symIn` within a clock period, with no clock edge in between.
- R9: Outside reset, `hit` is 1 exactly when the current symbol is c and the two symbols accepted on the two previous edges since reset were a then b (the run a,a,b,c matches).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| symIn | input | 2 | Encoded input symbol |
| hit | output | 1 | Combinational match flag, high while the pattern completes |

## Verification
The bench goes after the restart paths. A design that dropped to idle on an `a` in the final state would miss a,b,a,b,c. A design that dropped to idle on a repeated `a` in the middle state would miss a,a,b,c. The bench also changes the symbol in the middle of a cycle while the machine waits for `c`. A registered (Moore-like) output would then lag by one edge and fail the same-cycle check. It also asserts reset while the machine is armed and presents a `c`, which catches a flag that is not gated by reset. A long random stream with seeded a,b,c runs is compared each cycle against a history-based model.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  localparam int SYM_W = 2;

  typedef enum logic [SYM_W-1:0] {
    SYM_A     = 2'b00,
    SYM_B     = 2'b01,
    SYM_C     = 2'b10,
    SYM_OTHER = 2'b11
  } symbol_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_GOT_A  = 2'b01,
    ST_GOT_AB = 2'b10
  } state_t;

  // Decoded symbol flags, datapath -> control
  typedef struct packed {
    logic isA;
    logic isB;
    logic isC;
  } symFlags_t;

  // Strobes, control -> datapath
  typedef struct packed {
    logic armed;
    logic inReset;
  } ctlStrobes_t;
endpackage

// File: rtl/seqdet_ctrl.sv
module seqdet_ctrl
  import seqdet_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  symFlags_t   flags,
  output ctlStrobes_t strobes
);
  state_t curState, nxtState;

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nxtState;
  end

  always_comb begin
    nxtState = ST_IDLE;
    unique case (curState)
      ST_IDLE:   nxtState = flags.isA ? ST_GOT_A : ST_IDLE;
      ST_GOT_A: begin
        if (flags.isB)      nxtState = ST_GOT_AB;
        else if (flags.isA) nxtState = ST_GOT_A;
        else                nxtState = ST_IDLE;
      end
      ST_GOT_AB: nxtState = flags.isA ? ST_GOT_A : ST_IDLE;
      default:   nxtState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.armed   = (curState == ST_GOT_AB);
    strobes.inReset = rst;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> curState == ST_IDLE);
  p_idle_a_r3: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_IDLE && flags.isA) |=> curState == ST_GOT_A);
  p_b_arms_r4: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_GOT_A && flags.isB) |=> strobes.armed);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (strobes.armed && flags.isC) |=> curState == ST_IDLE);
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (strobes.armed && flags.isA) |=> curState == ST_GOT_A);
  p_legal_state_r9: assert property (@(posedge clk) disable iff (rst)
    curState != 2'b11);
endmodule

// File: rtl/seqdet_dp.sv
module seqdet_dp
  import seqdet_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SYM_W-1:0]  symIn,
  input  ctlStrobes_t       strobes,
  output symFlags_t         flags,
  output logic              hit
);
  symbol_t sym;

  always_comb begin
    sym       = symbol_t'(symIn);
    flags.isA = (sym == SYM_A);
    flags.isB = (sym == SYM_B);
    flags.isC = (sym == SYM_C);
    hit       = strobes.armed && flags.isC && !strobes.inReset;
  end

  p_hit_only_on_c_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> symIn == 2'b10);
  p_hit_once_r9: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/seqdet_top.sv
module seqdet_top
  import seqdet_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] symIn,
  output logic             hit
);
  symFlags_t   flags;
  ctlStrobes_t strobes;

  seqdet_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .flags   (flags),
    .strobes (strobes)
  );

  seqdet_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .symIn   (symIn),
    .strobes (strobes),
    .flags   (flags),
    .hit     (hit)
  );
endmodule

// File: tb/seqdet_top_bench.sv
`timescale 1ns/1ps
module seqdet_top_bench;
  localparam logic [1:0] A = 2'b00, B = 2'b01, C = 2'b10, O = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] symIn = O;
  logic       hit;

  int errs   = 0;
  int checks = 0;
  logic [1:0] h1 = O, h2 = O;   // h1 = previous symbol, h2 = the one before

  always #4 clk = ~clk;   // 125 MHz

  seqdet_top u_seqdet_top (.clk(clk), .rst(rst), .symIn(symIn), .hit(hit));

  task automatic check(input logic exp, input string req);
    checks++;
    if (hit !== exp) begin
      errs++;
      $display("FAIL %s: hit=%b expected=%b (sym=%b)", req, hit, exp, symIn);
    end
  endtask

  // Drive a symbol, check the same-cycle flag against the history model, clock it
  task automatic apply(input logic [1:0] s, input string req);
    @(negedge clk);
    symIn = s;
    #1;
    check((h2 == A && h1 == B && s == C), req);
    @(posedge clk);
    h2 = h1;
    h1 = s;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; symIn = O;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    h1 = O; h2 = O;
  endtask

  task automatic t_reset();   // R1
    @(negedge clk); rst = 1'b1; symIn = C; #1;
    check(1'b0, "R1 reset holds hit low");
    doReset();
    apply(C, "R1 lone c after reset");
  endtask

  task automatic t_basic();   // R2 R3 R5
    doReset();
    apply(B, "R3 idle ignores b");
    apply(C, "R3 idle ignores c");
    apply(A, "R3 idle a");
    apply(B, "R2 b code");
    apply(C, "R5 abc hits");
    apply(C, "R5 back to idle after hit");
  endtask

  task automatic t_mid();   // R4
    doReset();
    apply(A, "R4"); apply(A, "R4 a holds"); apply(B, "R4 aab");
    apply(C, "R9 aabc hits");
    apply(A, "R4"); apply(O, "R4 other to idle"); apply(B, "R4"); apply(C, "R4 no hit");
    apply(A, "R4"); apply(C, "R4 c to idle"); apply(C, "R4 no hit");
  endtask

  task automatic t_restart();   // R6
    doReset();
    apply(A, "R6"); apply(B, "R6"); apply(A, "R6 restart no hit");
    apply(B, "R6"); apply(C, "R6 ababc hits");
  endtask

  task automatic t_drop();   // R7
    doReset();
    apply(A, "R7"); apply(B, "R7"); apply(B, "R7 b drops");
    apply(C, "R7 no hit after abb");
    apply(A, "R7"); apply(B, "R7"); apply(O, "R7 other drops");
    apply(C, "R7 no hit after ab-other");
  endtask

  task automatic t_comb();   // R8
    doReset();
    apply(A, "R8"); apply(B, "R8");
    @(negedge clk); symIn = O; #1;
    check(1'b0, "R8 armed, other");
    symIn = C; #1;
    check(1'b1, "R8 same-cycle rise on c");
    symIn = B; #1;
    check(1'b0, "R8 falls with input");
    symIn = C; #1;
    @(posedge clk);
    h2 = B; h1 = C;
    apply(O, "R8 idle after hit");
  endtask

  task automatic t_resetArmed();   // R1
    doReset();
    apply(A, "R1"); apply(B, "R1");
    @(negedge clk); rst = 1'b1; symIn = C; #1;
    check(1'b0, "R1 reset masks armed hit");
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    h1 = O; h2 = O;
    apply(C, "R1 c after reset no hit");
  endtask

  task automatic t_random();   // R9
    doReset();
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) begin
        apply(A, "R9 seeded"); apply(B, "R9 seeded"); apply(C, "R9 seeded");
      end else begin
        apply(2'($urandom_range(0, 3)), "R9 random");
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    t_reset();
    t_basic();
    t_mid();
    t_restart();
    t_drop();
    t_comb();
    t_resetArmed();
    t_random();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule